// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block merges a stream of single-cycle completion pulses into one level-sensitive interrupt line. Rather than interrupting once per completion, it gathers completions into a window and raises the interrupt only when enough of them have arrived, or when the oldest one in the window has waited long enough. Software acknowledges the interrupt with a one-cycle pulse. That pulse empties the window and lets the next window begin.

One 32-bit configuration word sets the behaviour. The low half is a latency limit counted in 64 ns ticks. With the default `TICK_DIV` of 8, one tick is 8 cycles of a 125 MHz clock. The next nine bits are the completion-count threshold. When both fields are zero, coalescing is off and each completion raises the interrupt at once. The word is written through a plain write strobe. A window keeps the settings that were in force when its first completion arrived.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: After reset, `irq_o` is low and both configuration fields are zero, so the first completion raises `irq_o` at the edge that samples it.
- R2: Word bits 15:0 are the latency limit in ticks of `TICK_DIV` clock cycles. Bits 24:16 are the count threshold, an unsigned 9-bit number.
- R3: Word bits 31:25 are ignored. Words that differ only in those bits give identical interrupt timing.
- R4: When both fields are zero, every completion raises `irq_o` at the clock edge that samples it.
- R5: If the threshold T is nonzero, `irq_o` rises at the edge that samples the completion bringing the window's pending count to T.
- R6: If the latency limit L is nonzero, `irq_o` rises L*TICK_DIV cycles after the edge that sampled the window's first completion. Later completions do not restart this timer. A zero limit disables the latency trigger.
- R7: When both fields are nonzero, `irq_o` rises at whichever trigger comes first.
- R8: Once high, `irq_o` stays high until `ack_i`. At the edge that samples `ack_i` without a completion, it falls.
- R9: A completion sampled in the same cycle as `ack_i` counts as the first completion of the next window. If that completion alone meets the next window's trigger, `irq_o` stays high.
- R10: A configuration write made while a window is open changes neither that window's triggers nor an interrupt that is already asserted. The new values apply from the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: latency 15:0, threshold 24:16, 31:25 ignored |
| evt_i | input | 1 | One-cycle pulse per completion |
| ack_i | input | 1 | Acknowledge pulse that closes the current window |
| irq_o | output | 1 | Coalesced interrupt, level |

## Verification
Several properties are checked on every cycle:
- an asserted interrupt holds until acknowledged, even across configuration writes;
- an acknowledge with no completion always drops it;
- a completion under an all-zero configuration always raises it on the next cycle;
- each rising edge has a completion or a latency expiry behind it.

The exact cycle at which the count and latency triggers fire, which of the two wins, and how the per-window configuration snapshot behaves after a mid-window write depend on a sequence of events. Only the bench's timed scenarios can show those.

// File: rtl/icc_pkg.sv
package icc_pkg;

  // Window life cycle: nothing pending, collecting completions, interrupt raised.
  typedef enum logic [1:0] {
    WIN_IDLE   = 2'd0,
    WIN_GATHER = 2'd1,
    WIN_RAISED = 2'd2
  } win_state_e;

endpackage

// File: rtl/icc_cfg_regs.sv
module icc_cfg_regs #(
  parameter int DATA_W  = 32,
  parameter int LAT_W   = 16,
  parameter int CNT_W   = 9,
  parameter int LAT_LSB = 0,
  parameter int CNT_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  output logic [LAT_W-1:0]  stg_lat,
  output logic [CNT_W-1:0]  stg_thr,
  output logic [LAT_W-1:0]  win_lat,
  output logic [CNT_W-1:0]  win_thr
);

  // Staged copy: follows register writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_lat <= '0;
      stg_thr <= '0;
    end else if (we) begin
      stg_lat <= wdata[LAT_LSB +: LAT_W];
      stg_thr <= wdata[CNT_LSB +: CNT_W];
    end
  end

  // Window copy: frozen when a window opens.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_lat <= '0;
      win_thr <= '0;
    end else if (capture) begin
      win_lat <= stg_lat;
      win_thr <= stg_thr;
    end
  end

endmodule

// File: rtl/icc_pending_ctr.sv
module icc_pending_ctr #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    if (clear) begin
      cnt_next = evt ? CNT_W'(1) : '0;
    end else if (evt && cnt_q != CNT_MAX) begin
      cnt_next = cnt_q + CNT_W'(1);
    end else begin
      cnt_next = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

endmodule

// File: rtl/icc_latency_timer.sv
module icc_latency_timer #(
  parameter int LAT_W    = 16,
  parameter int TICK_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [LAT_W-1:0] limit,
  output logic             hit
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [LAT_W-1:0] TICK_MAX = {LAT_W{1'b1}};

  logic             tick;
  logic [LAT_W-1:0] ticks_q;

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else if (run)     pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + PW'(1);
      end
      assign tick = run && (pre_q == PRE_LAST);
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ticks_q <= '0;
    else if (restart)                      ticks_q <= '0;
    else if (tick && ticks_q != TICK_MAX)  ticks_q <= ticks_q + LAT_W'(1);
  end

  assign hit = tick && (limit != '0) &&
               (({1'b0, ticks_q} + (LAT_W+1)'(1)) == {1'b0, limit});

endmodule

// File: rtl/cmpl_irq_coalescer.sv
module cmpl_irq_coalescer #(
  parameter int DATA_W   = 32,
  parameter int LAT_W    = 16,
  parameter int CNT_W    = 9,
  parameter int LAT_LSB  = 0,
  parameter int CNT_LSB  = 16,
  parameter int TICK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              evt_i,
  input  logic              ack_i,
  output logic              irq_o
);
  import icc_pkg::*;

  win_state_e       state_q, state_d;
  logic [LAT_W-1:0] stg_lat, win_lat, use_lat;
  logic [CNT_W-1:0] stg_thr, win_thr, use_thr;
  logic [CNT_W-1:0] pend_cnt, pend_next;
  logic             win_open, start, passthru, cnt_hit, lat_hit, tmr_run;

  assign win_open = (state_q != WIN_IDLE);
  // A completion opens a window when none is open, or when an ack closes the old one.
  assign start    = evt_i && (!win_open || ack_i);

  icc_cfg_regs #(
    .DATA_W(DATA_W), .LAT_W(LAT_W), .CNT_W(CNT_W),
    .LAT_LSB(LAT_LSB), .CNT_LSB(CNT_LSB)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .capture(start),
    .stg_lat(stg_lat), .stg_thr(stg_thr),
    .win_lat(win_lat), .win_thr(win_thr)
  );

  icc_pending_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(ack_i), .evt(evt_i),
    .cnt_q(pend_cnt), .cnt_next(pend_next)
  );

  assign tmr_run = (state_q == WIN_GATHER) && !ack_i;

  icc_latency_timer #(.LAT_W(LAT_W), .TICK_DIV(TICK_DIV)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(start || ack_i), .run(tmr_run),
    .limit(win_lat), .hit(lat_hit)
  );

  assign use_lat  = start ? stg_lat : win_lat;
  assign use_thr  = start ? stg_thr : win_thr;
  assign passthru = (use_lat == '0) && (use_thr == '0);
  assign cnt_hit  = evt_i && (passthru || ((use_thr != '0) && (pend_next >= use_thr)));

  always_comb begin
    state_d = state_q;
    if (ack_i) begin
      if (start) state_d = cnt_hit ? WIN_RAISED : WIN_GATHER;
      else       state_d = WIN_IDLE;
    end else begin
      unique case (state_q)
        WIN_IDLE:   if (evt_i) state_d = cnt_hit ? WIN_RAISED : WIN_GATHER;
        WIN_GATHER: if (cnt_hit || lat_hit) state_d = WIN_RAISED;
        WIN_RAISED: state_d = WIN_RAISED;
        default:    state_d = WIN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WIN_IDLE;
    else        state_q <= state_d;
  end

  assign irq_o = (state_q == WIN_RAISED);

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int LAT_W = 16,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_i,
  input logic             ack_i,
  input logic             cfg_we,
  input logic             irq_o,
  input logic             win_open,
  input logic             lat_hit,
  input logic [CNT_W-1:0] pend_cnt,
  input logic [LAT_W-1:0] stg_lat,
  input logic [CNT_W-1:0] stg_thr
);

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> irq_o);

  assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !evt_i) |=> !irq_o);

  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && (ack_i || !win_open) && stg_lat == '0 && stg_thr == '0) |=> irq_o);

  assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(evt_i) || $past(lat_hit)));

  assert_write_keeps_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && cfg_we && !ack_i) |=> irq_o);

  assert_idle_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> (pend_cnt == '0));

endmodule

bind cmpl_irq_coalescer icc_checker #(.LAT_W(LAT_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ack_i(ack_i), .cfg_we(cfg_we),
  .irq_o(irq_o), .win_open(win_open), .lat_hit(lat_hit),
  .pend_cnt(pend_cnt), .stg_lat(stg_lat), .stg_thr(stg_thr)
);

// File: tb/cmpl_irq_coalescer_tb_top.sv
module cmpl_irq_coalescer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        evt_i = 1'b0;
  logic        ack_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmpl_irq_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .evt_i(evt_i), .ack_i(ack_i), .irq_o(irq_o)
  );

  // Vector table: config word, completion count, spacing, expected rise cycle (-1: none)
  localparam int NV = 11;
  localparam int WIN_LIMIT = 120;
  localparam logic [31:0] V_CFG [NV] = '{
    32'h0000_0000, 32'h0003_0000, 32'h0004_0000, 32'h0000_0002,
    32'h0005_0003, 32'h0005_0001, 32'hFE00_0000, 32'hAA03_0000,
    32'h0002_0000, 32'h0001_0000, 32'h0000_0001 };
  localparam int V_N   [NV] = '{1, 5, 4, 1, 10, 10, 1, 5, 1, 1, 3};
  localparam int V_GAP [NV] = '{1, 1, 3, 1, 2, 4, 1, 1, 1, 1, 2};
  localparam int V_EXP [NV] = '{0, 2, 9, 16, 8, 8, 0, 2, -1, 0, 8};
  localparam string V_REQ [NV] = '{"R4", "R5", "R5", "R6", "R7", "R7",
                                    "R3", "R3", "R6", "R2", "R6"};

  task automatic cyc(input logic e, input logic a);
    evt_i = e;
    ack_i = a;
    @(negedge clk);
    evt_i = 1'b0;
    ack_i = 1'b0;
  endtask

  task automatic wr_cfg(input logic [31:0] w);
    cfg_we = 1'b1;
    cfg_wdata = w;
    cyc(1'b0, 1'b0);
    cfg_we = 1'b0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and default pass-through
    chk("R1 irq after reset", int'(irq_o), 0);
    cyc(1'b1, 1'b0);
    chk("R1 default passthrough", int'(irq_o), 1);
    cyc(1'b0, 1'b1);
    chk("R8 ack release", int'(irq_o), 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      int first;
      bit dropped;
      first = -1;
      dropped = 1'b0;
      cyc(1'b0, 1'b1);
      wr_cfg(V_CFG[v]);
      cyc(1'b0, 1'b0);
      for (int c = 0; c < WIN_LIMIT; c++) begin
        cyc((c < V_N[v] * V_GAP[v]) && (c % V_GAP[v] == 0), 1'b0);
        if (irq_o && first < 0) first = c;
        if (first >= 0 && !irq_o) dropped = 1'b1;
      end
      chk(V_REQ[v], first, V_EXP[v]);
      chk("R8 held until ack", int'(dropped), 0);
    end
    cyc(1'b0, 1'b1);
    chk("R8 ack clears", int'(irq_o), 0);

    // R9: completion with ack belongs to next window (threshold 2)
    wr_cfg(32'h0002_0000);
    cyc(1'b1, 1'b0);
    chk("R9 one of two", int'(irq_o), 0);
    cyc(1'b1, 1'b0);
    chk("R9 threshold reached", int'(irq_o), 1);
    cyc(1'b1, 1'b1);
    chk("R9 ack with event drops", int'(irq_o), 0);
    cyc(1'b1, 1'b0);
    chk("R9 carried event counted", int'(irq_o), 1);
    cyc(1'b0, 1'b1);

    // R9: threshold 1, ack with event re-raises
    wr_cfg(32'h0001_0000);
    cyc(1'b1, 1'b0);
    chk("R9 thr1 raise", int'(irq_o), 1);
    cyc(1'b1, 1'b1);
    chk("R9 thr1 refire", int'(irq_o), 1);
    cyc(1'b0, 1'b1);
    chk("R8 final release", int'(irq_o), 0);

    // R10: mid-window write does not change current window
    wr_cfg(32'h0004_0000);
    cyc(1'b1, 1'b0);
    wr_cfg(32'h0001_0000);
    cyc(1'b1, 1'b0);
    chk("R10 old threshold kept", int'(irq_o), 0);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    chk("R10 old threshold fires", int'(irq_o), 1);
    wr_cfg(32'h0001_0000);
    cyc(1'b0, 1'b0);
    chk("R10 write keeps irq", int'(irq_o), 1);
    cyc(1'b0, 1'b1);
    chk("R10 ack release", int'(irq_o), 0);
    cyc(1'b1, 1'b0);
    chk("R10 new threshold next window", int'(irq_o), 1);
    cyc(1'b0, 1'b1);

    finish_run();
  end

endmodule